// File: doc/BRIEF.md
# Per-Thread Issue-Slot Counter Bank

This block keeps four always-running performance counters for every logical thread of a simultaneous-multithreaded core. Together they sort each issue slot into a top-down stall category. Every cycle, each thread's slot-capacity counter grows by the fixed issue width. The occupancy counter grows by the number of instructions waiting to issue for that thread. The dispatch counter grows by how many of those instructions actually left. The completion counter grows by the number of instructions that retired. Software derives front-end stalls, back-end stalls and wasted speculation from differences and ratios of these four values.

There is no event selection and no global enable, so any code may read the counters at any time. A read names a thread and a counter, and the value appears one cycle later. A write port loads any counter with a new value. This lets an operating system save and restore per-process copies across a context switch. Each thread has a sticky flag. The flag records any cycle in which the occupancy or dispatch inputs broke their ordering rules. The offending input is clamped before it is added.

Top module: `issue_slot_counters`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears all counters, all error flags, `rd_valid` and `rd_data` to zero.
- R2: In every cycle that carries no write to it, the slot-capacity counter (select code 0) of every thread adds ISSUE_W (default 4), whatever that thread's inputs are.
- R3: The occupancy counter (select code 1) adds the thread's fill count F when F <= ISSUE_W.
- R4: The dispatch counter (select code 2) adds the thread's issue count I when I <= F.
- R5: The completion counter (select code 3) adds the thread's retire count R. R may be as large as RET_MAX (default 8), which is above ISSUE_W.
- R6: Each thread's inputs change only that thread's counters and error flag. Thread t's fields sit at bits [t*W +: W] of each packed input bus.
- R7: When `rd_en` is high at an edge, `rd_data` holds the selected counter's value from just before that edge for the following cycle, and `rd_valid` is high. When `rd_en` is low, `rd_valid` is low in the following cycle.
- R8: A write (`wr_en` high) loads `wr_data` into the counter picked by `wr_thread` and `wr_sel`. That counter's increment for that cycle is dropped, and all other counters still increment. A read of the same counter in the same cycle returns the old value.
- R9: If F > ISSUE_W, F is clamped to ISSUE_W before accumulation, and the thread's error flag is set.
- R10: If I exceeds the (clamped) F, I is clamped to that F, and the thread's error flag is set.
- R11: Counters are CNT_W (64) bits wide and wrap modulo 2^CNT_W without any indication.
- R12: An error flag, once set, stays set until reset. Legal inputs and writes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_cnt | input | NUM_THREADS*FI_W | Per-thread instructions available to issue (F) |
| issue_cnt | input | NUM_THREADS*FI_W | Per-thread instructions issued (I) |
| retire_cnt | input | NUM_THREADS*RET_W | Per-thread instructions retired (R) |
| rd_en | input | 1 | Read request |
| rd_thread | input | TH_W | Thread index of the read |
| rd_sel | input | 2 | Counter select of the read: 0 capacity, 1 occupancy, 2 dispatch, 3 completion |
| rd_data | output | CNT_W | Read result, valid the cycle after the request |
| rd_valid | output | 1 | High for the cycle that follows a read request |
| wr_en | input | 1 | Counter load request |
| wr_thread | input | TH_W | Thread index of the load |
| wr_sel | input | 2 | Counter select of the load (same encoding as rd_sel) |
| wr_data | input | CNT_W | Value to load |
| err_flags | output | NUM_THREADS | Sticky per-thread input-violation flags |

## Verification
The bench sweeps every legal combination of F, I and R on one thread while the other thread runs a different pattern, and reads a different counter every cycle. A design that mixed threads, or that used the wrong adder input for a counter, would return a value off from the running sum. Out-of-range F and I are swept separately on each thread. A design that clamped in the wrong order, or that flagged the wrong thread, would diverge in the occupancy or dispatch totals or in the flag pattern. Writes are checked for a dropped increment and for reading back the old value in the same cycle. A load near the top of the range catches a counter that saturates or carries into a wider register instead of wrapping.

// File: rtl/slot_ctr_pkg.sv
// Shared definitions for the issue-slot counter bank.
// Assumes every thread owns exactly four counters addressed by a 2-bit select.
package slot_ctr_pkg;

    // Counter select codes used by both the read and the load port.
    typedef enum logic [1:0] {
        SEL_TOTAL   = 2'd0,
        SEL_FILLED  = 2'd1,
        SEL_ISSUED  = 2'd2,
        SEL_RETIRED = 2'd3
    } ctr_sel_e;

    localparam int NUM_CTRS = 4;

endpackage

// File: rtl/slot_sanitize.sv
// Clamps one thread's fill and issue counts to their legal bounds.
// F is bounded by the issue width; I is bounded by the clamped F.
// Assumes FI_W can hold ISSUE_W.
module slot_sanitize #(
    parameter int ISSUE_W = 4,
    parameter int FI_W    = 3
) (
    input  logic [FI_W-1:0] fill_raw,
    input  logic [FI_W-1:0] issue_raw,
    output logic [FI_W-1:0] fill_ok,
    output logic [FI_W-1:0] issue_ok,
    output logic            bad
);
    localparam logic [FI_W-1:0] T_VAL = FI_W'(ISSUE_W);

    // Purpose: apply both bounds in order and report any violation.
    always_comb begin
        fill_ok  = (fill_raw > T_VAL) ? T_VAL : fill_raw;
        issue_ok = (issue_raw > fill_ok) ? fill_ok : issue_raw;
        bad      = (fill_raw > T_VAL) || (issue_raw > fill_ok);
    end
endmodule

// File: rtl/thread_counter_set.sv
// The four counters and the sticky error flag of one logical thread.
// A load to a counter wins over that counter's increment in the same cycle.
// Assumes inputs are already clamped by slot_sanitize.
module thread_counter_set
    import slot_ctr_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int FI_W    = 3,
    parameter int RET_W   = 4,
    parameter int CNT_W   = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [FI_W-1:0]               fill_ok,
    input  logic [FI_W-1:0]               issue_ok,
    input  logic [RET_W-1:0]              retire,
    input  logic                          viol,
    input  logic                          ld_en,
    input  logic [1:0]                    ld_sel,
    input  logic [CNT_W-1:0]              ld_data,
    output logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_o,
    output logic                          err_o
);
    logic [NUM_CTRS-1:0][CNT_W-1:0] inc;
    logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_q;

    // Purpose: form the per-counter step for this cycle.
    always_comb begin
        inc[SEL_TOTAL]   = CNT_W'(ISSUE_W);
        inc[SEL_FILLED]  = CNT_W'(fill_ok);
        inc[SEL_ISSUED]  = CNT_W'(issue_ok);
        inc[SEL_RETIRED] = CNT_W'(retire);
    end

    // Purpose: accumulate each counter, or load it when addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            for (int k = 0; k < NUM_CTRS; k++) begin
                if (ld_en && (ld_sel == 2'(k)))
                    cnt_q[k] <= ld_data;
                else
                    cnt_q[k] <= cnt_q[k] + inc[k];
            end
        end
    end

    // Purpose: hold the violation flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (viol)
            err_o <= 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/counter_read_port.sv
// Registered read of one counter chosen by thread index and select.
// The result reflects counter values sampled at the request edge.
// Assumes thread indices at or above NUM_THREADS read as zero.
module counter_read_port
    import slot_ctr_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int CNT_W       = 64,
    parameter int TH_W        = 1
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NUM_THREADS-1:0][NUM_CTRS-1:0][CNT_W-1:0] cnt_all,
    input  logic                                        rd_en,
    input  logic [TH_W-1:0]                             rd_thread,
    input  logic [1:0]                                  rd_sel,
    output logic [CNT_W-1:0]                            rd_data,
    output logic                                        rd_valid
);
    logic [CNT_W-1:0] pick;

    // Purpose: select the addressed counter combinationally.
    always_comb begin
        pick = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (rd_thread == TH_W'(t))
                pick = cnt_all[t][rd_sel];
        end
    end

    // Purpose: register the selected value and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= pick;
        end
    end
endmodule

// File: rtl/issue_slot_counters.sv
// Top of the per-thread issue-slot counter bank.
// One sanitizer and one counter set per thread, plus a shared read port.
// Assumes RET_MAX >= ISSUE_W so the retire input is the widest count.
module issue_slot_counters
    import slot_ctr_pkg::*;
#(
    parameter  int NUM_THREADS = 2,
    parameter  int ISSUE_W     = 4,
    parameter  int RET_MAX     = 8,
    parameter  int CNT_W       = 64,
    localparam int FI_W        = $clog2(ISSUE_W + 1),
    localparam int RET_W       = $clog2(RET_MAX + 1),
    localparam int TH_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS*FI_W-1:0]  fill_cnt,
    input  logic [NUM_THREADS*FI_W-1:0]  issue_cnt,
    input  logic [NUM_THREADS*RET_W-1:0] retire_cnt,
    input  logic                         rd_en,
    input  logic [TH_W-1:0]              rd_thread,
    input  logic [1:0]                   rd_sel,
    output logic [CNT_W-1:0]             rd_data,
    output logic                         rd_valid,
    input  logic                         wr_en,
    input  logic [TH_W-1:0]              wr_thread,
    input  logic [1:0]                   wr_sel,
    input  logic [CNT_W-1:0]             wr_data,
    output logic [NUM_THREADS-1:0]       err_flags
);
    logic [NUM_THREADS-1:0][NUM_CTRS-1:0][CNT_W-1:0] cnt_all;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic [FI_W-1:0] fill_ok;
        logic [FI_W-1:0] issue_ok;
        logic            bad;
        logic            ld_here;

        // Purpose: decode whether the load port targets this thread.
        assign ld_here = wr_en && (wr_thread == TH_W'(t));

        slot_sanitize #(
            .ISSUE_W (ISSUE_W),
            .FI_W    (FI_W)
        ) u_clamp (
            .fill_raw  (fill_cnt[t*FI_W +: FI_W]),
            .issue_raw (issue_cnt[t*FI_W +: FI_W]),
            .fill_ok   (fill_ok),
            .issue_ok  (issue_ok),
            .bad       (bad)
        );

        thread_counter_set #(
            .ISSUE_W (ISSUE_W),
            .FI_W    (FI_W),
            .RET_W   (RET_W),
            .CNT_W   (CNT_W)
        ) u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill_ok  (fill_ok),
            .issue_ok (issue_ok),
            .retire   (retire_cnt[t*RET_W +: RET_W]),
            .viol     (bad),
            .ld_en    (ld_here),
            .ld_sel   (wr_sel),
            .ld_data  (wr_data),
            .cnt_o    (cnt_all[t]),
            .err_o    (err_flags[t])
        );
    end

    counter_read_port #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W),
        .TH_W        (TH_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_all   (cnt_all),
        .rd_en     (rd_en),
        .rd_thread (rd_thread),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/issue_slot_counters_chk.sv
// Temporal checks on the counter bank, bound into every instance of the top.
// Assumes the counter array is laid out [thread][select].
module issue_slot_counters_chk #(
    parameter  int NUM_THREADS = 2,
    parameter  int ISSUE_W     = 4,
    parameter  int CNT_W       = 64,
    localparam int TH_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   rd_en,
    input logic [TH_W-1:0]                        rd_thread,
    input logic [1:0]                             rd_sel,
    input logic [CNT_W-1:0]                       rd_data,
    input logic                                   rd_valid,
    input logic                                   wr_en,
    input logic [TH_W-1:0]                        wr_thread,
    input logic [1:0]                             wr_sel,
    input logic [CNT_W-1:0]                       wr_data,
    input logic [NUM_THREADS-1:0]                 err_flags,
    input logic [NUM_THREADS-1:0][3:0][CNT_W-1:0] cnt_all
);
    // Purpose: look up a counter by thread and select.
    function automatic logic [CNT_W-1:0] pick(
        input logic [NUM_THREADS-1:0][3:0][CNT_W-1:0] arr,
        input logic [TH_W-1:0] th,
        input logic [1:0]      sel
    );
        logic [CNT_W-1:0] v;
        v = '0;
        for (int t = 0; t < NUM_THREADS; t++)
            if (th == TH_W'(t)) v = arr[t][sel];
        return v;
    endfunction

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_valid == $past(rd_en)));

    p_read_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(pick(cnt_all, rd_thread, rd_sel))));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pick(cnt_all, $past(wr_thread), $past(wr_sel)) == $past(wr_data)));

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_tot
        p_total_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_thread == TH_W'(t)) && (wr_sel == 2'd0))
            |=> (cnt_all[t][0] == $past(cnt_all[t][0]) + CNT_W'(ISSUE_W)));
    end
endmodule

bind issue_slot_counters issue_slot_counters_chk #(
    .NUM_THREADS (NUM_THREADS),
    .ISSUE_W     (ISSUE_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_thread (rd_thread),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wr_en     (wr_en),
    .wr_thread (wr_thread),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .err_flags (err_flags),
    .cnt_all   (cnt_all)
);

// File: tb/issue_slot_counters_tb.sv
`timescale 1ns/1ps
// Sweeping bench for the counter bank: two threads, width 4, retire up to 8.
module issue_slot_counters_tb;
    localparam int NT = 2;
    localparam int TW = 4;
    localparam int FW = 3;
    localparam int RW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT*FW-1:0]  fill_cnt = '0;
    logic [NT*FW-1:0]  issue_cnt = '0;
    logic [NT*RW-1:0]  retire_cnt = '0;
    logic              rd_en = 1'b0;
    logic              rd_thread = 1'b0;
    logic [1:0]        rd_sel = 2'd0;
    logic [63:0]       rd_data;
    logic              rd_valid;
    logic              wr_en = 1'b0;
    logic              wr_thread = 1'b0;
    logic [1:0]        wr_sel = 2'd0;
    logic [63:0]       wr_data = '0;
    logic [NT-1:0]     err_flags;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string rd_tag = "";
    string err_tag = "R9";

    logic [63:0] m [NT][4];
    logic        merr [NT];

    always #2 clk = ~clk;

    issue_slot_counters u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_cnt   (fill_cnt),
        .issue_cnt  (issue_cnt),
        .retire_cnt (retire_cnt),
        .rd_en      (rd_en),
        .rd_thread  (rd_thread),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .wr_en      (wr_en),
        .wr_thread  (wr_thread),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .err_flags  (err_flags)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_in(input int t, input int f, input int i, input int r);
        fill_cnt[t*FW +: FW]   = FW'(f);
        issue_cnt[t*FW +: FW]  = FW'(i);
        retire_cnt[t*RW +: RW] = RW'(r);
    endtask

    function automatic string sel_tag(input logic th, input logic [1:0] s);
        if (th) return "R6";
        case (s)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One clock: update the model from the current inputs, then check outputs.
    task automatic cyc();
        logic [63:0] exp_rd;
        logic        was_rd;
        string       tag;
        was_rd = rd_en;
        exp_rd = m[rd_thread][rd_sel];
        tag = (rd_tag != "") ? rd_tag : sel_tag(rd_thread, rd_sel);
        for (int t = 0; t < NT; t++) begin
            int f, i, r, fc, ic;
            f  = int'(fill_cnt[t*FW +: FW]);
            i  = int'(issue_cnt[t*FW +: FW]);
            r  = int'(retire_cnt[t*RW +: RW]);
            fc = (f > TW) ? TW : f;
            ic = (i > fc) ? fc : i;
            if (f > TW || i > fc) merr[t] = 1'b1;
            m[t][0] = m[t][0] + 64'(TW);
            m[t][1] = m[t][1] + 64'(fc);
            m[t][2] = m[t][2] + 64'(ic);
            m[t][3] = m[t][3] + 64'(r);
            if (wr_en && wr_thread == 1'(t)) m[t][wr_sel] = wr_data;
        end
        @(posedge clk);
        #1;
        check(rd_valid == was_rd, "R7", 64'(rd_valid), 64'(was_rd));
        if (was_rd) check(rd_data == exp_rd, tag, rd_data, exp_rd);
        check(err_flags == {merr[1], merr[0]}, err_tag, 64'(err_flags), 64'({merr[1], merr[0]}));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_en = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(rd_valid == 1'b0, "R1", 64'(rd_valid), 64'd0);
        check(rd_data == '0, "R1", rd_data, 64'd0);
        check(err_flags == '0, "R1", 64'(err_flags), 64'd0);
        for (int t = 0; t < NT; t++) begin
            merr[t] = 1'b0;
            for (int k = 0; k < 4; k++) m[t][k] = '0;
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        set_in(0, 0, 0, 0);
        set_in(1, 0, 0, 0);
        do_reset();

        // R1: the first reads after reset see zero counters.
        rd_tag = "R1";
        rd_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            rd_thread = 1'(k / 4);
            rd_sel = 2'(k % 4);
            cyc();
        end
        rd_tag = "";

        // R2..R6: all legal F/I/R on thread 0, a different pattern on thread 1.
        n = 0;
        for (int f = 0; f <= TW; f++)
            for (int i = 0; i <= f; i++)
                for (int r = 0; r <= 8; r++) begin
                    set_in(0, f, i, r);
                    set_in(1, (f + 2) % 5, ((f + 2) % 5) / 2, 8 - r);
                    rd_thread = 1'(n / 4 % 2);
                    rd_sel = 2'(n % 4);
                    rd_en = (n % 7 != 6);
                    n++;
                    cyc();
                end
        rd_en = 1'b1;

        // R9: oversized F on thread 1 only.
        err_tag = "R9";
        for (int f = 5; f <= 7; f++)
            for (int i = 0; i <= 7; i++) begin
                set_in(0, 2, 1, 3);
                set_in(1, f, i, 1);
                rd_thread = 1'b1;
                rd_sel = 2'(1 + i % 2);
                cyc();
            end

        // R10: issue above fill on thread 0.
        err_tag = "R10";
        for (int f = 0; f <= 3; f++)
            for (int i = f + 1; i <= 7; i++) begin
                set_in(0, f, i, 2);
                set_in(1, 1, 1, 1);
                rd_thread = 1'b0;
                rd_sel = 2'(1 + i % 2);
                rd_tag = (rd_sel == 2'd2) ? "R10" : "R9";
                cyc();
            end
        rd_tag = "";

        // R12: flags stay set through legal inputs and a load.
        err_tag = "R12";
        for (int k = 0; k < 6; k++) begin
            set_in(0, 1, 0, 0);
            set_in(1, 4, 4, 4);
            wr_en = (k == 2);
            wr_thread = 1'b0;
            wr_sel = 2'd2;
            wr_data = 64'd77;
            rd_thread = 1'(k % 2);
            rd_sel = 2'(k % 4);
            cyc();
        end
        wr_en = 1'b0;

        // R8: load thread 0 occupancy while reading it and while F=3.
        rd_tag = "R8";
        set_in(0, 3, 2, 1);
        wr_en = 1'b1;
        wr_thread = 1'b0;
        wr_sel = 2'd1;
        wr_data = 64'd1000;
        rd_thread = 1'b0;
        rd_sel = 2'd1;
        cyc();
        wr_en = 1'b0;
        cyc();
        cyc();
        rd_sel = 2'd0;
        cyc();

        // R11: wrap of thread 1 completion counter.
        rd_tag = "R11";
        wr_en = 1'b1;
        wr_thread = 1'b1;
        wr_sel = 2'd3;
        wr_data = 64'hFFFF_FFFF_FFFF_FFFD;
        set_in(1, 0, 0, 5);
        rd_thread = 1'b1;
        rd_sel = 2'd3;
        cyc();
        wr_en = 1'b0;
        cyc();
        cyc();
        check(rd_data == 64'd2, "R11", rd_data, 64'd2);
        wr_en = 1'b1;
        wr_sel = 2'd0;
        wr_data = 64'hFFFF_FFFF_FFFF_FFFE;
        rd_sel = 2'd0;
        cyc();
        wr_en = 1'b0;
        cyc();
        cyc();

        // R1: a second reset clears the sticky flags and counters.
        err_tag = "R1";
        do_reset();
        rd_tag = "R1";
        rd_en = 1'b1;
        set_in(0, 0, 0, 0);
        set_in(1, 0, 0, 0);
        for (int k = 0; k < 8; k++) begin
            rd_thread = 1'(k % 2);
            rd_sel = 2'(k / 2);
            cyc();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule